// File: doc/BRIEF.md
# Packed Subword Shift and Rotate Unit

This block applies one shift-class operation to every subword of a 64-bit packed operand in parallel. The lane width is chosen per operation as 8, 16 or 32 bits. The operations are logical left shift, logical right shift, arithmetic right shift, left rotate, and a fused shift-left-then-add. No bit, carry or sign ever moves from one lane into another.

The second operand supplies the shift or rotate distance in one of two ways. In uniform mode, a single distance taken from the low byte of the second operand applies to every lane. In per-lane mode, each lane reads its own distance from the matching lane of the second operand. The fused operation shifts each lane of the first operand left by a two-bit constant, then adds the matching lane of the second operand. The sum wraps within the lane.

An operation is presented with `in_valid`. Its result is registered and appears together with `out_valid` one clock later. The unit has no stall and accepts one operation every cycle.

Top module: `psr_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `result` is loaded only on a cycle with `in_valid` high, and holds its value on every other cycle.
- R2: While `rst_n` is low, `out_valid` and `result` are driven to zero.
- R3: The lane width is selected by `size_sel`: 0 selects 8-bit lanes, 1 selects 16-bit lanes, and both 2 and 3 select 32-bit lanes. Every result lane depends only on the matching lanes of `opa` and `opb`.
- R4: The operation is selected by `op_sel` as follows: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate left, and 4 is shift-then-add. Codes 5, 6 and 7 produce an all-zero result.
- R5: When `per_lane` is 0, the distance is the unsigned value of `opb[7:0]`, and every lane uses it.
- R6: When `per_lane` is 1, lane i uses the low log2(W) bits of lane i of `opb`. The upper bits of that lane do not affect the result.
- R7: A logical shift by a distance of W or more yields zero. An arithmetic right shift by such a distance fills the lane with copies of its sign bit.
- R8: A rotate moves each lane left by its distance modulo W. Bits leaving the top of the lane re-enter at the bottom.
- R9: Shift-then-add computes each lane as (opa lane << `add_shift`) + opb lane, modulo 2^W, where `add_shift` ranges from 0 to 3. The `per_lane` input has no effect on this operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Lane width code |
| per_lane | input | 1 | 1 selects a distance per lane, 0 selects one common distance |
| add_shift | input | 2 | Left shift applied before the add in shift-then-add |
| opa | input | 64 | Packed data operand |
| opb | input | 64 | Distance operand, or addend for shift-then-add |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Packed result |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and an 8-bit uniform distance field. These defaults expose all three lane widths at once.

With an 8-bit field, uniform distances run up to 255. That range reaches past every lane width, so the saturating shift cases and the rotate-modulo cases are exercised for 8-, 16- and 32-bit lanes alike. Per-lane operands carry random upper bits, which shows that those bits are ignored.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [2:0] {
        OP_SLL   = 3'd0,
        OP_SRL   = 3'd1,
        OP_SRA   = 3'd2,
        OP_ROL   = 3'd3,
        OP_SHADD = 3'd4,
        OP_RSV5  = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } psr_op_e;

    typedef enum logic [1:0] {
        SZ_B8   = 2'd0,
        SZ_B16  = 2'd1,
        SZ_B32  = 2'd2,
        SZ_B32X = 2'd3
    } psr_size_e;

endpackage

// File: rtl/psr_lane.sv
module psr_lane
    import psr_pkg::*;
#(
    parameter int W   = 8,
    parameter int UAW = 8
) (
    input  psr_op_e        op,
    input  logic           per_lane,
    input  logic [UAW-1:0] uni_amt,
    input  logic [1:0]     add_shift,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   y_o
);
    localparam int AW = $clog2(W);

    logic [UAW-1:0] amt;
    logic           over;
    logic [AW-1:0]  sh;
    logic [W-1:0]   sll_v, srl_v, sra_v, rol_v, add_v;
    logic [2*W-1:0] dbl;

    always_comb begin
        // distance source: lane field or common byte
        amt  = per_lane ? UAW'(b_i[AW-1:0]) : uni_amt;
        over = (amt >= UAW'(W));
        sh   = amt[AW-1:0];

        sll_v = over ? '0 : (a_i << sh);
        srl_v = over ? '0 : (a_i >> sh);
        sra_v = over ? {W{a_i[W-1]}} : W'($signed(a_i) >>> sh);

        // rotate: left shift of the doubled lane, upper half kept
        dbl   = {a_i, a_i} << sh;
        rol_v = dbl[2*W-1:W];

        add_v = (a_i << add_shift) + b_i;

        unique case (op)
            OP_SLL:   y_o = sll_v;
            OP_SRL:   y_o = srl_v;
            OP_SRA:   y_o = sra_v;
            OP_ROL:   y_o = rol_v;
            OP_SHADD: y_o = add_v;
            default:  y_o = '0;
        endcase
    end
endmodule

// File: rtl/psr_lane_array.sv
module psr_lane_array
    import psr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int UAW    = 8
) (
    input  psr_op_e           op,
    input  logic              per_lane,
    input  logic [UAW-1:0]    uni_amt,
    input  logic [1:0]        add_shift,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);
    localparam int NLANE = DATA_W / LANE_W;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        psr_lane #(.W(LANE_W), .UAW(UAW)) i_lane (
            .op       (op),
            .per_lane (per_lane),
            .uni_amt  (uni_amt),
            .add_shift(add_shift),
            .a_i      (a_i[g*LANE_W +: LANE_W]),
            .b_i      (b_i[g*LANE_W +: LANE_W]),
            .y_o      (y_o[g*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int UAW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic              per_lane,
    input  logic [1:0]        add_shift,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int NSZ = 3;

    psr_op_e           op;
    psr_size_e         sz;
    logic [UAW-1:0]    uni_amt;
    logic [DATA_W-1:0] y_sz [NSZ];
    logic [DATA_W-1:0] y_sel;

    assign op      = psr_op_e'(op_sel);
    assign sz      = psr_size_e'(size_sel);
    assign uni_amt = opb[UAW-1:0];

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        psr_lane_array #(.DATA_W(DATA_W), .LANE_W(8 << s), .UAW(UAW)) i_arr (
            .op       (op),
            .per_lane (per_lane),
            .uni_amt  (uni_amt),
            .add_shift(add_shift),
            .a_i      (opa),
            .b_i      (opb),
            .y_o      (y_sz[s])
        );
    end

    always_comb begin
        unique case (sz)
            SZ_B8:   y_sel = y_sz[0];
            SZ_B16:  y_sel = y_sz[1];
            SZ_B32,
            SZ_B32X: y_sel = y_sz[2];
            default: y_sel = y_sz[2];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= y_sel;
        end
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R1
    AST_SLL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd0 && !per_lane && opb[7:0] >= 8'd32) |=> result == '0); // R7
    AST_SRA_SIGNFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd2 && !per_lane && size_sel[1] && opb[7:0] >= 8'd32)
        |=> result[DATA_W-1:DATA_W-32] == {32{$past(opa[DATA_W-1])}}); // R7
    AST_ROL_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 3'd3 && !per_lane && opb[4:0] == 5'd0) |=> result == $past(opa)); // R8
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 3'd5) |=> result == '0); // R4
endmodule

// File: tb/test_psr_unit.sv
module test_psr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic        per_lane = 1'b0;
    logic [1:0]  add_shift = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit live = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_exp = '0;

    always #10 clk = ~clk;

    psr_unit i_psr_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .size_sel(size_sel), .per_lane(per_lane), .add_shift(add_shift),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input int op, input int sz, input bit per,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input int n);
        logic [63:0] r;
        int w;
        r = '0;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        if (op > 4) return '0;
        for (int l = 0; l < 64 / w; l++) begin
            logic [31:0] av, bv, ov;
            int amt;
            av = '0; bv = '0; ov = '0;
            for (int k = 0; k < w; k++) begin
                av[k] = a[l*w + k];
                bv[k] = b[l*w + k];
            end
            amt = per ? int'(bv % w) : int'(b[7:0]);
            if (op == 4) begin
                longint s;
                s = (longint'(av) << n) + longint'(bv);
                for (int k = 0; k < w; k++) ov[k] = s[k];
            end else begin
                for (int k = 0; k < w; k++) begin
                    case (op)
                        0: ov[k] = (k >= amt) ? av[k - amt] : 1'b0;
                        1: ov[k] = (k + amt < w) ? av[k + amt] : 1'b0;
                        2: ov[k] = (k + amt < w) ? av[k + amt] : av[w-1];
                        default: ov[k] = av[(k - (amt % w) + w) % w];
                    endcase
                end
            end
            for (int k = 0; k < w; k++) r[l*w + k] = ov[k];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input string req, input int op, input int sz, input bit per,
                         input logic [63:0] a, input logic [63:0] b, input int n);
        @(negedge clk);
        in_valid  = 1'b1;
        op_sel    = op[2:0];
        size_sel  = sz[1:0];
        per_lane  = per;
        add_shift = n[1:0];
        opa = a;
        opb = b;
        exp_q.push_back(model(op, sz, per, a, b, n));
        tag_q.push_back(req);
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opa = $urandom();
            opb = $urandom();
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (live) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R1 unexpected valid", {63'd0, out_valid}, 64'd0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, result, e);
                    last_exp = e;
                end
            end else begin
                check("R1 hold while idle", result, last_exp);
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset valid", {63'd0, out_valid}, 64'd0);
        check("R2 reset result", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        live = 1;

        // R5 uniform shifts across sizes
        drive("R5 sll b8 by3", 0, 0, 0, 64'h8142_F00F_0123_4567, 64'h3, 0);
        drive("R5 srl b16 by5", 1, 1, 0, 64'h8142_F00F_0123_4567, 64'h5, 0);
        drive("R5 sra b32 by4", 2, 2, 0, 64'h8142_F00F_7123_4567, 64'h4, 0);
        idle(2);
        // R7 saturation
        drive("R7 sll b8 by8", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8, 0);
        drive("R7 srl b16 by200", 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hC8, 0);
        drive("R7 sra b8 by9", 2, 0, 0, 64'h80_7F_81_01_FF_00_C0_3F, 64'h9, 0);
        drive("R7 sra b32 by32", 2, 2, 0, 64'h8000_0000_7FFF_FFFF, 64'h20, 0);
        drive("R7 sra b16 by15", 2, 1, 0, 64'h8000_7FFF_C000_4000, 64'hF, 0);
        // R8 rotates
        drive("R8 rol b8 by9", 3, 0, 0, 64'h8142_F00F_0123_4567, 64'h9, 0);
        drive("R8 rol b16 by16", 3, 1, 0, 64'h8142_F00F_0123_4567, 64'h10, 0);
        drive("R8 rol b32 by31", 3, 2, 0, 64'h8142_F00F_0123_4567, 64'h1F, 0);
        // R6 per-lane, upper bits junk
        drive("R6 sll b8 per-lane", 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF8_F1_A2_53_C4_D5_E6_07, 0);
        drive("R6 sra b16 per-lane", 2, 1, 1, 64'h8000_8000_4000_F0F0, 64'hFFF0_0011_00E3_0F2F, 0);
        drive("R6 rol b32 per-lane", 3, 2, 1, 64'h8000_0001_1234_5678, 64'hFFFF_FFE1_0000_0104, 0);
        // R9 shift-then-add, wrap, per_lane ignored
        drive("R9 shadd b8 n3", 4, 0, 0, 64'hFF_20_01_00_7F_80_10_33, 64'h01_02_03_04_05_06_07_08, 3);
        drive("R9 shadd b16 n1 per", 4, 1, 1, 64'hFFFF_8000_1234_0001, 64'h0001_8000_1111_FFFF, 1);
        drive("R9 shadd b32 n0", 4, 2, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 0);
        // R4 reserved, R3 size code 3
        drive("R4 reserved op5", 5, 0, 0, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1, 0);
        drive("R4 reserved op7", 7, 2, 1, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1, 0);
        drive("R3 size3 as 32", 1, 3, 0, 64'h8000_0000_8000_0000, 64'h1F, 0);
        idle(3);

        // R3 lane isolation and mixed random coverage
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            drive("R3 random mix", int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                  bit'($urandom_range(0, 1)), ra, rb, int'($urandom_range(0, 3)));
            if ((i % 37) == 0) idle(2);
        end
        idle(4);
        check("R1 queue drained", 64'(exp_q.size()), 64'd0);

        // R2 reset mid-stream
        drive("R2 pre-reset", 0, 0, 0, 64'h1, 64'h1, 0);
        @(negedge clk);
        live = 0;
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 reset valid again", {63'd0, out_valid}, 64'd0);
        check("R2 reset result again", result, 64'd0);
        finish_run();
    end
endmodule